// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Data Cache

This block is the data cache between a 32-bit byte-addressed processor and a slow main memory. It stores 16 KB of data as 256 sets of four ways, each way one valid bit, one dirty bit, a 20-bit tag and a block of four 32-bit words. The processor issues one word read or write per request on a valid/ready port. The cache answers each request with a one-cycle response pulse that carries the read data.

On a lookup, all four ways of the indexed set are compared in parallel. Hits are served from the array. A write hit only updates the array and marks the way dirty. A miss picks a victim way. If the victim holds modified data, the controller first copies its block to memory, then fetches the missing block and repeats the lookup. That second lookup always hits, so a read miss and an allocating write miss end the same way as a hit.

The memory side moves whole four-word blocks, one per request/acknowledge transaction, with a read/write select. Victim choice uses the lowest free way when one exists. Otherwise it uses a three-bit tree of most-recently-used bits kept for each set.

Top module: `cache_ctrl`

## Requirements
- R1: The address is split as tag = bits [31:12], set = bits [11:4], word = bits [3:2]. Bits [1:0] have no effect on which word is read or written.
- R2: A request is accepted on a rising edge where `cpu_valid` and `cpu_ready` are both high. On a read hit, `cpu_resp` is high with the word in `cpu_rdata` for one cycle, starting at the second rising edge after acceptance.
- R3: A write hit replaces the addressed word in the block and marks that way dirty. It causes no memory transaction.
- R4: A read miss fetches the block with one memory read. It installs the block valid and clean, then returns the requested word from it.
- R5: A write miss allocates: it fetches the block with one memory read, then writes the word and marks the way dirty. No memory write happens for that request unless the victim was dirty.
- R6: A victim that is valid and dirty is written to memory, with its own block address and contents, before the fetch starts. A clean victim is dropped with no memory write.
- R7: While any way of the set is invalid, the victim is the lowest-numbered invalid way.
- R8: Each set keeps three bits u0, u1 and u2, cleared by reset and updated on every hit, including the hit that ends a miss. A hit in way 0 sets u0=1 and u1=0. Way 1 sets u0=1 and u1=1. Way 2 sets u0=0 and u2=1. Way 3 sets u0=0 and u2=0. When all four ways are valid, the victim is way 3 if u0=1 and u2=1, way 2 if u0=1 and u2=0, way 0 if u0=0 and u1=1, and way 1 if u0=0 and u1=0.
- R9: Reset clears every valid and dirty bit. After reset, `cpu_ready` is high and `mem_req` and `cpu_resp` are low. A block that was cached and dirty before reset misses afterwards, with no write-back.
- R10: `cpu_ready` is low from acceptance until the response, and in particular while `mem_req` is high. `mem_req`, `mem_we` and `mem_addr` stay stable until the rising edge where `mem_ack` is high. `mem_addr` is block-aligned (bits [3:0] zero), and `mem_wdata`/`mem_rdata` hold word n in bits [32n+31:32n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Word to write |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read word, valid with `cpu_resp` |
| mem_req | output | 1 | Block transaction requested |
| mem_we | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Block being written back |
| mem_rdata | input | 128 | Fetched block, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the transaction |

## Verification
The bench fills one set until every way is valid. It then forces evictions whose victims alternate between clean and dirty ways, in the order the replacement tree predicts. A design that mis-updated the tree, or ignored a free way, would evict a different block, and the counts of fetches and write-backs for the next requests would change. Reads of blocks that were evicted while dirty must return the values written earlier. A cache that skipped the write-back, or wrote back the wrong block, returns the stale memory pattern instead. A mid-run reset followed by a read of a block that was dirty before the reset must produce a fetch with no write-back. A design that kept valid or dirty bits through reset would instead hit, or write the block back.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
package cache_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int TREE_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WBACK, ST_FILL} ctrl_state_t;

  // tree bits: [0] last use in ways 0/1, [1] way 1 newer than way 0, [2] way 2 newer than way 3
  function automatic logic [WAY_W-1:0] tree_victim(input logic [TREE_W-1:0] t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    else      return t[1] ? 2'd0 : 2'd1;
  endfunction

  function automatic logic [TREE_W-1:0] tree_touch(input logic [TREE_W-1:0] t,
                                                   input logic [WAY_W-1:0] w);
    logic [TREE_W-1:0] r;
    r = t;
    case (w)
      2'd0: begin r[0] = 1'b1; r[1] = 1'b0; end
      2'd1: begin r[0] = 1'b1; r[1] = 1'b1; end
      2'd2: begin r[0] = 1'b0; r[2] = 1'b1; end
      default: begin r[0] = 1'b0; r[2] = 1'b0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cache_way_match.sv
`timescale 1ns/1ps
module cache_way_match #(
  parameter int TAG_W = 20,
  parameter int N     = 4,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]        tag_i,
  output logic [N-1:0]            hit_o,
  output logic [SEL_W-1:0]        way_o,
  output logic                    any_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int i = 0; i < N; i++)
      if (hit_o[i]) way_o = SEL_W'(i);
  end

  assign any_o = |hit_o;
endmodule

// File: rtl/cache_victim_pick.sv
`timescale 1ns/1ps
module cache_victim_pick
  import cache_pkg::*;
(
  input  logic [WAYS-1:0]   valid_i,
  input  logic [TREE_W-1:0] tree_i,
  output logic [WAY_W-1:0]  victim_o
);
  logic             free_found;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!valid_i[i]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(i);
      end
  end

  assign victim_o = free_found ? free_way : tree_victim(tree_i);
endmodule

// File: rtl/cache_ctrl.sv
`timescale 1ns/1ps
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SET_BITS  = 8,
  parameter int WORD_BITS = 2,
  localparam int BYTE_BITS = $clog2(DATA_W / 8),
  localparam int IDX_LSB   = BYTE_BITS + WORD_BITS,
  localparam int TAG_LSB   = IDX_LSB + SET_BITS,
  localparam int TAG_W     = ADDR_W - TAG_LSB,
  localparam int SETS      = 1 << SET_BITS,
  localparam int BLK_W     = (1 << WORD_BITS) * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_resp,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic [BLK_W-1:0]  mem_rdata,
  input  logic              mem_ack
);
  function automatic logic [DATA_W-1:0] blk_get(input logic [BLK_W-1:0] b,
                                                input logic [WORD_BITS-1:0] w);
    return b[int'(w)*DATA_W +: DATA_W];
  endfunction

  function automatic logic [BLK_W-1:0] blk_put(input logic [BLK_W-1:0] b,
                                               input logic [WORD_BITS-1:0] w,
                                               input logic [DATA_W-1:0] d);
    logic [BLK_W-1:0] r;
    r = b;
    r[int'(w)*DATA_W +: DATA_W] = d;
    return r;
  endfunction

  // storage
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [TREE_W-1:0] tree_q  [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [BLK_W-1:0]  data_q  [SETS][WAYS];

  // request registers
  ctrl_state_t              state_q;
  logic                     req_we_q;
  logic [ADDR_W-1:IDX_LSB]  req_line_q;
  logic [WORD_BITS-1:0]     req_word_q;
  logic [DATA_W-1:0]        req_wdata_q;
  logic [WAY_W-1:0]         vway_q;
  logic                     resp_q;
  logic [DATA_W-1:0]        rdata_q;

  logic unused_byte_bits;
  assign unused_byte_bits = ^cpu_addr[BYTE_BITS-1:0];

  logic [SET_BITS-1:0] req_idx;
  logic [TAG_W-1:0]    req_tag;
  assign req_idx = req_line_q[TAG_LSB-1:IDX_LSB];
  assign req_tag = req_line_q[ADDR_W-1:TAG_LSB];

  logic [WAYS-1:0]            set_valid;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  always_comb begin
    set_valid = valid_q[req_idx];
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[req_idx][w];
  end

  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way;
  logic             any_hit;
  logic [WAY_W-1:0] victim_way;

  cache_way_match #(.TAG_W(TAG_W), .N(WAYS)) i_match (
    .valid_i(set_valid), .tags_i(set_tags), .tag_i(req_tag),
    .hit_o(hit_vec), .way_o(hit_way), .any_o(any_hit)
  );

  cache_victim_pick i_victim (
    .valid_i(set_valid), .tree_i(tree_q[req_idx]), .victim_o(victim_way)
  );

  // named internal events
  logic ev_accept, ev_hit, ev_miss, ev_wb_done, ev_fill_done, victim_dirty;
  assign ev_accept    = cpu_valid && cpu_ready;
  assign ev_hit       = (state_q == ST_LOOK) && any_hit;
  assign ev_miss      = (state_q == ST_LOOK) && !any_hit;
  assign ev_wb_done   = (state_q == ST_WBACK) && mem_ack;
  assign ev_fill_done = (state_q == ST_FILL) && mem_ack;
  assign victim_dirty = set_valid[victim_way] && dirty_q[req_idx][victim_way];

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_we_q    <= 1'b0;
      req_line_q  <= '0;
      req_word_q  <= '0;
      req_wdata_q <= '0;
      vway_q      <= '0;
      resp_q      <= 1'b0;
      rdata_q     <= '0;
    end else begin
      resp_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (ev_accept) begin
          req_we_q    <= cpu_write;
          req_line_q  <= cpu_addr[ADDR_W-1:IDX_LSB];
          req_word_q  <= cpu_addr[IDX_LSB-1:BYTE_BITS];
          req_wdata_q <= cpu_wdata;
          state_q     <= ST_LOOK;
        end
        ST_LOOK: if (any_hit) begin
          resp_q  <= 1'b1;
          rdata_q <= blk_get(data_q[req_idx][hit_way], req_word_q);
          state_q <= ST_IDLE;
        end else begin
          vway_q  <= victim_way;
          state_q <= victim_dirty ? ST_WBACK : ST_FILL;
        end
        ST_WBACK: if (ev_wb_done)   state_q <= ST_FILL;
        default:  if (ev_fill_done) state_q <= ST_LOOK;
      endcase
    end
  end

  // state bits with reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        tree_q[s]  <= '0;
      end
    end else begin
      if (ev_fill_done) begin
        valid_q[req_idx][vway_q] <= 1'b1;
        dirty_q[req_idx][vway_q] <= 1'b0;
      end
      if (ev_hit) begin
        tree_q[req_idx] <= tree_touch(tree_q[req_idx], hit_way);
        if (req_we_q) dirty_q[req_idx][hit_way] <= 1'b1;
      end
    end
  end

  // tag and data arrays, no reset
  always_ff @(posedge clk) begin
    if (ev_fill_done) begin
      tag_q[req_idx][vway_q]  <= req_tag;
      data_q[req_idx][vway_q] <= mem_rdata;
    end else if (ev_hit && req_we_q) begin
      data_q[req_idx][hit_way] <= blk_put(data_q[req_idx][hit_way], req_word_q, req_wdata_q);
    end
  end

  assign cpu_ready = (state_q == ST_IDLE);
  assign cpu_resp  = resp_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_addr  = (state_q == ST_WBACK)
                   ? {tag_q[req_idx][vway_q], req_idx, {IDX_LSB{1'b0}}}
                   : {req_tag, req_idx, {IDX_LSB{1'b0}}};
  assign mem_wdata = data_q[req_idx][vway_q];

  // assertions
  a_r3_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOK) |-> $onehot0(hit_vec));
  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> ev_hit);
  a_r6_wb_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
  a_r6_clean_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && !victim_dirty) |=> (mem_req && !mem_we));
  a_r7_free_way_used: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_miss && !(&set_valid)) |-> !set_valid[victim_way]);
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
  a_r2_resp_after_look: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_resp) |-> $past(state_q == ST_LOOK));
endmodule

// File: tb/test_cache_ctrl.sv
`timescale 1ns/1ps
module test_cache_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0;
  logic         cpu_ready;
  logic         cpu_write = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_resp;
  logic [31:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ack = 1'b0;

  always #5 clk = ~clk;

  cache_ctrl i_cache_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int total = 0;
  int bad = 0;
  int fills = 0;
  int wbs = 0;
  int misalign = 0;
  int ready_busy = 0;
  int dly = 0;

  logic [127:0] mem_blk [logic [27:0]];
  logic [31:0]  shadow  [logic [29:0]];

  function automatic logic [127:0] pattern_blk(input logic [27:0] ba);
    logic [127:0] b;
    for (int w = 0; w < 4; w++) b[w*32 +: 32] = {ba, 2'(w), 2'b10} ^ 32'h5A00_0000;
    return b;
  endfunction

  function automatic logic [127:0] read_blk(input logic [27:0] ba);
    if (mem_blk.exists(ba)) return mem_blk[ba];
    return pattern_blk(ba);
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [127:0] b;
    if (shadow.exists(a[31:2])) return shadow[a[31:2]];
    b = read_blk(a[31:4]);
    return b[int'(a[3:2])*32 +: 32];
  endfunction

  function automatic logic [31:0] mk(input logic [19:0] tg, input logic [7:0] st,
                                     input logic [1:0] wd);
    return {tg, st, wd, 2'b00};
  endfunction

  // memory responder: acknowledges two cycles after a request appears
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      dly = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      dly = 0;
    end else if (mem_req) begin
      if (cpu_ready) ready_busy++;
      if (mem_addr[3:0] != 4'd0) misalign++;
      if (dly == 2) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem_blk[mem_addr[31:4]] = mem_wdata;
          wbs++;
        end else begin
          mem_rdata <= read_blk(mem_addr[31:4]);
          fills++;
        end
        dly = 0;
      end else dly++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_write = we;
    cpu_addr  = a;
    cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    lat = 1;
    while (!cpu_resp) begin
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
    if (we) shadow[a[31:2]] = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    shadow.delete();
  endtask

  typedef struct packed {
    logic        we;
    logic [7:0]  tg;
    logic [7:0]  st;
    logic [1:0]  wd;
    logic [31:0] dat;
    logic [1:0]  nf;
    logic [1:0]  nw;
  } vec_t;

  // all in set 5 except the last; expected fetch/write-back counts per request
  localparam vec_t VECS [14] = '{
    '{1'b0, 8'd1, 8'd5, 2'd0, 32'h0,         2'd1, 2'd0},  // R4 R7 way0
    '{1'b0, 8'd1, 8'd5, 2'd3, 32'h0,         2'd0, 2'd0},  // R2 hit
    '{1'b1, 8'd2, 8'd5, 2'd1, 32'h1111_2222, 2'd1, 2'd0},  // R5 way1
    '{1'b0, 8'd2, 8'd5, 2'd1, 32'h0,         2'd0, 2'd0},  // R5 read back
    '{1'b0, 8'd3, 8'd5, 2'd0, 32'h0,         2'd1, 2'd0},  // R7 way2
    '{1'b1, 8'd4, 8'd5, 2'd2, 32'h3333_4444, 2'd1, 2'd0},  // R7 way3
    '{1'b0, 8'd5, 8'd5, 2'd0, 32'h0,         2'd1, 2'd0},  // R8 evicts way0 clean
    '{1'b0, 8'd1, 8'd5, 2'd3, 32'h0,         2'd1, 2'd0},  // R8 evicts way2 clean
    '{1'b0, 8'd3, 8'd5, 2'd1, 32'h0,         2'd1, 2'd1},  // R6 evicts way1 dirty
    '{1'b0, 8'd2, 8'd5, 2'd1, 32'h0,         2'd1, 2'd1},  // R6 evicts way3 dirty
    '{1'b0, 8'd4, 8'd5, 2'd2, 32'h0,         2'd1, 2'd0},  // R6 data came back
    '{1'b1, 8'd4, 8'd5, 2'd2, 32'h5555_6666, 2'd0, 2'd0},  // R3 write hit
    '{1'b0, 8'd4, 8'd5, 2'd2, 32'h0,         2'd0, 2'd0},  // R3 read back
    '{1'b0, 8'd1, 8'd6, 2'd0, 32'h0,         2'd1, 2'd0}   // R7 other set
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, a, ex;
    int lat, f0, w0;

    do_reset();
    check("R9 ready after reset", 32'(cpu_ready), 32'd1);
    check("R9 mem_req after reset", 32'(mem_req), 32'd0);
    check("R9 resp after reset", 32'(cpu_resp), 32'd0);

    for (int i = 0; i < 14; i++) begin
      a  = mk({12'd0, VECS[i].tg}, VECS[i].st, VECS[i].wd);
      ex = exp_word(a);
      f0 = fills;
      w0 = wbs;
      do_req(VECS[i].we, a, VECS[i].dat, rd, lat);
      if (!VECS[i].we) check($sformatf("R4 R6 read data vec %0d", i), rd, ex);
      check($sformatf("R4 R5 R7 R8 fetch count vec %0d", i), 32'(fills - f0), 32'(VECS[i].nf));
      check($sformatf("R3 R6 write-back count vec %0d", i), 32'(wbs - w0), 32'(VECS[i].nw));
      if (VECS[i].nf == 2'd0) check($sformatf("R2 hit latency vec %0d", i), 32'(lat), 32'd2);
    end

    // word select within the block just fetched in set 6
    for (int w = 1; w < 4; w++) begin
      a = mk(20'd1, 8'd6, 2'(w));
      f0 = fills;
      do_req(1'b0, a, 32'h0, rd, lat);
      check($sformatf("R1 word %0d select", w), rd, exp_word(a));
      check("R1 no fetch on hit", 32'(fills - f0), 32'd0);
    end

    // byte offset bits have no effect on reads or writes
    a = mk(20'd1, 8'd6, 2'd2);
    do_req(1'b0, a | 32'd3, 32'h0, rd, lat);
    check("R1 byte offset ignored on read", rd, exp_word(a));
    do_req(1'b1, a | 32'd1, 32'hCAFE_0001, rd, lat);
    shadow[a[31:2]] = 32'hCAFE_0001;
    do_req(1'b0, a, 32'h0, rd, lat);
    check("R1 byte offset ignored on write", rd, 32'hCAFE_0001);
    do_req(1'b0, a + 32'd4, 32'h0, rd, lat);
    check("R1 neighbour word untouched", rd, exp_word(a + 32'd4));

    // reset drops dirty data without write-back
    do_reset();
    check("R9 ready after second reset", 32'(cpu_ready), 32'd1);
    a = mk(20'd4, 8'd5, 2'd2);
    f0 = fills;
    w0 = wbs;
    do_req(1'b0, a, 32'h0, rd, lat);
    check("R9 miss after reset", 32'(fills - f0), 32'd1);
    check("R9 no write-back after reset", 32'(wbs - w0), 32'd0);
    check("R9 memory copy returned", rd, 32'h3333_4444);

    check("R10 ready low while memory busy", 32'(ready_busy), 32'd0);
    check("R10 block aligned memory address", 32'(misalign), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule